// File: doc/BRIEF.md
# Video Control Signal Glitch Filter

This block cleans up the three slow video framing signals (data-enable, horizontal sync and vertical sync) on the pixel clock before they are handed to a serial link transmitter. Each signal runs through its own channel. A channel accepts a new level only after it has been held long enough. It also forwards no more than a fixed number of accepted edges inside any sliding 130-clock window. Rejected transitions are reported on a one-cycle strobe for that signal.

Each channel is a small state machine. WARM waits one cycle for the input register to fill. PRIME takes the first observed level as the baseline and moves to IDLE. IDLE stays put while the input matches the accepted level. When the input differs, IDLE either decides at once (minimum width of one) or moves to QUAL. QUAL counts the run length. It returns to IDLE when the input falls back early (glitch reject), or when the run reaches the minimum width and the budget allows the edge (accept). It moves to BLOCK when the run reaches the minimum width but the budget is spent (budget reject). BLOCK returns to IDLE once the input matches the accepted level again.

Accepted edges go through a delay line whose tap depends on the active minimum width. Every output edge therefore appears a fixed 131 clocks after the input edge, and the three signals keep their relative timing.

Top module: `vidctl_glitch_filter`

## Requirements
- R1: While reset is active and after it is released, all outputs and strobes are low until a level is forwarded. The first sampled level of each input becomes its baseline: a high baseline drives the output high without spending any transition budget and without a strobe.
- R2: An accepted edge on any input appears on the matching output exactly 131 clock edges after the input changes. This holds for every signal and for both filter settings.
- R3: With `filt_en` high, a DE or HS level held for 1 or 2 clocks is dropped and raises that signal's strobe. A level held for 3 clocks is forwarded.
- R4: With `filt_en` low, a DE or HS level of a single clock is forwarded.
- R5: DE and HS each forward at most 2 accepted edges in any 130-clock window. An edge beyond that is dropped and raises the strobe.
- R6: The window slides per edge. An edge decided 130 clocks after the older of two accepted edges is forwarded. One decided 129 clocks after is dropped.
- R7: A VS level shorter than 130 clocks is dropped with a strobe. A VS level of 130 clocks is forwarded.
- R8: Accepted VS edges are at least 130 clocks apart, so consecutive VS output edges are at least 130 clocks apart.
- R9: After a budget rejection, the output keeps its old level. When the input returns to that level, no further edge and no further strobe is produced.
- R10: A change of `filt_en` is applied to DE or HS only while that signal has no pulse under qualification. A pulse that is being qualified is judged by the setting it started with.
- R11: Each strobe is a single-cycle pulse per rejected transition and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Minimum-pulse filtering for DE and HS (1 = 3-clock minimum) |
| de_in | input | 1 | Raw data-enable |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_out | output | 1 | Filtered data-enable |
| hs_out | output | 1 | Filtered horizontal sync |
| vs_out | output | 1 | Filtered vertical sync |
| de_drop | output | 1 | Strobe: DE transition rejected |
| hs_drop | output | 1 | Strobe: HS transition rejected |
| vs_drop | output | 1 | Strobe: VS transition rejected |

## Verification
The hardest case to reach is the exact edge of the sliding window. The rejection depends on how old the older of two stored acceptances is, and nothing at the ports shows that age. The stimulus disables filtering so that a one-clock pulse is decided in a known cycle. It then starts a second pulse exactly 129 clocks later, and in a separate run exactly 130 clocks later. A pulse that straddles an enable change is handled the same way: the stimulus flips `filt_en` between the start of a pulse and its qualification cycle.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
    typedef enum logic [2:0] {
        ST_WARM,
        ST_PRIME,
        ST_IDLE,
        ST_QUAL,
        ST_BLOCK
    } chan_state_e;
endpackage

// File: rtl/vcf_window.sv
module vcf_window #(
    parameter int BUDGET = 2,
    parameter int WINDOW = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    output logic room
);
    localparam int AW = $clog2(WINDOW + 1);
    localparam int NW = $clog2(BUDGET + 1);

    logic [AW-1:0] age [BUDGET];
    logic [BUDGET-1:0] live;
    logic [BUDGET-1:0] pick;
    logic [NW-1:0] live_cnt;

    always_comb begin
        live_cnt = '0;
        for (int i = 0; i < BUDGET; i++) begin
            live[i] = (age[i] < AW'(WINDOW));
            live_cnt = live_cnt + NW'(live[i]);
        end
        pick = '0;
        for (int i = BUDGET - 1; i >= 0; i--) begin
            if (!live[i]) pick = BUDGET'(1) << i;
        end
    end

    assign room = (live_cnt < NW'(BUDGET));

    generate
        for (genvar g = 0; g < BUDGET; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    age[g] <= AW'(WINDOW);
                else if (push && pick[g])
                    age[g] <= AW'(1);
                else if (age[g] < AW'(WINDOW))
                    age[g] <= age[g] + AW'(1);
            end
        end
    endgenerate

    // R5: an accepted edge is only pushed while a slot is free
    a_r5_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (live_cnt < NW'(BUDGET)));
endmodule

// File: rtl/vcf_delay.sv
module vcf_delay #(
    parameter int LAT = 130
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push,
    input  logic [$clog2(LAT)-1:0] tap,
    output logic                   out
);
    logic [LAT-1:0] line;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
            out  <= 1'b0;
        end else begin
            line <= {line[LAT-2:0], push};
            out  <= out ^ line[tap];
        end
    end
endmodule

// File: rtl/vcf_channel.sv
module vcf_channel
    import vcf_pkg::*;
#(
    parameter int MINW   = 3,
    parameter int BUDGET = 2,
    parameter int WINDOW = 130,
    parameter int LAT    = 130,
    parameter bit HAS_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    output logic out,
    output logic drop
);
    localparam int CW = $clog2(LAT + 1);
    localparam int TW = $clog2(LAT);
    localparam int GW = $clog2(WINDOW + 1);

    chan_state_e   state, state_n;
    logic          s_in, lvl, lvl_n, en_q;
    logic [CW-1:0] cnt, cnt_n, minw;
    logic          accept, reject, prime_push, room, idle_now;
    logic [TW-1:0] tap;

    assign minw     = (HAS_EN && !en_q) ? CW'(1) : CW'(MINW);
    assign tap      = TW'(LAT) - TW'(minw);
    assign idle_now = (state == ST_IDLE && s_in == lvl) || state == ST_BLOCK;

    always_comb begin
        state_n    = state;
        lvl_n      = lvl;
        cnt_n      = cnt;
        accept     = 1'b0;
        reject     = 1'b0;
        prime_push = 1'b0;
        unique case (state)
            ST_WARM:  state_n = ST_PRIME;
            ST_PRIME: begin
                lvl_n      = s_in;
                prime_push = s_in;
                state_n    = ST_IDLE;
            end
            ST_IDLE: begin
                if (s_in != lvl) begin
                    if (minw == CW'(1)) begin
                        if (room) accept = 1'b1;
                        else begin
                            reject  = 1'b1;
                            state_n = ST_BLOCK;
                        end
                    end else begin
                        cnt_n   = CW'(1);
                        state_n = ST_QUAL;
                    end
                end
            end
            ST_QUAL: begin
                if (s_in == lvl) begin
                    reject  = 1'b1;
                    state_n = ST_IDLE;
                end else if (cnt + CW'(1) >= minw) begin
                    if (room) begin
                        accept  = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        reject  = 1'b1;
                        state_n = ST_BLOCK;
                    end
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            ST_BLOCK: if (s_in == lvl) state_n = ST_IDLE;
            default:  state_n = ST_WARM;
        endcase
        if (accept) lvl_n = ~lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WARM;
            lvl   <= 1'b0;
            cnt   <= '0;
            s_in  <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            state <= state_n;
            lvl   <= lvl_n;
            cnt   <= cnt_n;
            s_in  <= pin;
            if (idle_now) en_q <= en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drop <= 1'b0;
        else        drop <= reject;
    end

    vcf_window #(.BUDGET(BUDGET), .WINDOW(WINDOW)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .push (accept),
        .room (room)
    );

    vcf_delay #(.LAT(LAT)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .push (accept | prime_push),
        .tap  (tap),
        .out  (out)
    );

    // spacing tracker for the single-budget case
    logic [GW-1:0] gap;
    logic          had_acc;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            had_acc <= 1'b0;
        end else if (accept) begin
            gap     <= GW'(1);
            had_acc <= 1'b1;
        end else if (gap < GW'(WINDOW)) begin
            gap <= gap + GW'(1);
        end
    end

    // R8: with a budget of one, accepted edges are a full window apart
    a_r8_single_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (BUDGET == 1 && accept && had_acc) |-> (gap >= GW'(WINDOW)));
    // R11: a rejection strobe never lasts two cycles
    a_r11_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !drop);
    // R10: the filter setting is frozen while a pulse is qualified
    a_r10_en_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAL) |=> $stable(en_q));
    // R9: a blocked signal never moves its accepted level
    a_r9_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK) |=> $stable(lvl));
endmodule

// File: rtl/vidctl_glitch_filter.sv
module vidctl_glitch_filter #(
    parameter int WINDOW    = 130,
    parameter int DH_MINW   = 3,
    parameter int DH_BUDGET = 2,
    parameter int VS_MINW   = 130,
    parameter int VS_BUDGET = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic de_in,
    input  logic hs_in,
    input  logic vs_in,
    output logic de_out,
    output logic hs_out,
    output logic vs_out,
    output logic de_drop,
    output logic hs_drop,
    output logic vs_drop
);
    localparam int LAT = (VS_MINW > DH_MINW) ? VS_MINW : DH_MINW;

    vcf_channel #(.MINW(DH_MINW), .BUDGET(DH_BUDGET), .WINDOW(WINDOW),
                  .LAT(LAT), .HAS_EN(1'b1)) u_de (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .pin(de_in),
        .out(de_out), .drop(de_drop)
    );

    vcf_channel #(.MINW(DH_MINW), .BUDGET(DH_BUDGET), .WINDOW(WINDOW),
                  .LAT(LAT), .HAS_EN(1'b1)) u_hs (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .pin(hs_in),
        .out(hs_out), .drop(hs_drop)
    );

    vcf_channel #(.MINW(VS_MINW), .BUDGET(VS_BUDGET), .WINDOW(WINDOW),
                  .LAT(LAT), .HAS_EN(1'b0)) u_vs (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .pin(vs_in),
        .out(vs_out), .drop(vs_drop)
    );

    // R1: nothing is flagged while reset is applied on the previous edge
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        disable iff (!rst_n) $rose(rst_n) |-> !(de_drop | hs_drop | vs_drop));
endmodule

// File: tb/vidctl_glitch_filter_bench.sv
module vidctl_glitch_filter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic filt_en = 1'b1;
    logic de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic de_out, hs_out, vs_out, de_drop, hs_drop, vs_drop;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int tog [3];
    int drp [3];
    logic pv [3];
    int vs_last, vs_gap;

    always #2.5 clk = ~clk;

    vidctl_glitch_filter u_vidctl_glitch_filter (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en),
        .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
        .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out),
        .de_drop(de_drop), .hs_drop(hs_drop), .vs_drop(vs_drop)
    );

    // vector: sel[15:14] (0 DE,1 HS,2 VS), en[13], width[12:4], toggles[3:2], drops[1:0]
    localparam logic [15:0] VEC [9] = '{
        {2'd0, 1'b1, 9'd1,   2'd0, 2'd1},
        {2'd0, 1'b1, 9'd2,   2'd0, 2'd1},
        {2'd0, 1'b1, 9'd3,   2'd2, 2'd0},
        {2'd1, 1'b1, 9'd2,   2'd0, 2'd1},
        {2'd1, 1'b0, 9'd1,   2'd2, 2'd0},
        {2'd0, 1'b0, 9'd1,   2'd2, 2'd0},
        {2'd2, 1'b1, 9'd129, 2'd0, 2'd1},
        {2'd2, 1'b0, 9'd130, 2'd2, 2'd0},
        {2'd2, 1'b1, 9'd200, 2'd2, 2'd0}
    };
    string vtag [9] = '{"R3", "R3", "R3", "R3", "R4", "R4", "R7", "R7", "R7"};

    always @(negedge clk) begin
        logic cur [3];
        cur[0] = de_out; cur[1] = hs_out; cur[2] = vs_out;
        cyc++;
        for (int i = 0; i < 3; i++) begin
            if (cur[i] !== pv[i]) begin
                tog[i]++;
                if (i == 2) begin
                    vs_gap  = cyc - vs_last;
                    vs_last = cyc;
                end
            end
            pv[i] = cur[i];
        end
        if (de_drop) drp[0]++;
        if (hs_drop) drp[1]++;
        if (vs_drop) drp[2]++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        for (int i = 0; i < 3; i++) begin
            tog[i] = 0;
            drp[i] = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input int sel, input logic v);
        case (sel)
            0:       de_in = v;
            1:       hs_in = v;
            default: vs_in = v;
        endcase
    endtask

    task automatic pulse(input int sel, input int w);
        @(negedge clk);
        drive(sel, 1'b1);
        idle(w);
        drive(sel, 1'b0);
    endtask

    task automatic latency(input int sel, input logic en, input string tag);
        logic o;
        filt_en = en;
        idle(10);
        @(negedge clk);
        drive(sel, 1'b1);
        repeat (131) @(posedge clk);
        @(negedge clk);
        o = (sel == 0) ? de_out : (sel == 1) ? hs_out : vs_out;
        chk(o == 1'b0, tag, o, 0);
        @(posedge clk);
        @(negedge clk);
        o = (sel == 0) ? de_out : (sel == 1) ? hs_out : vs_out;
        chk(o == 1'b1, tag, o, 1);
        idle(200);
        drive(sel, 1'b0);
        idle(300);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) pv[i] = 1'b0;
        clr();
        vs_last = 0;
        vs_gap  = 0;
        // R1: reset with a high DE baseline
        de_in = 1'b1;
        filt_en = 1'b1;
        idle(5);
        chk({de_out, hs_out, vs_out} == 3'b000, "R1 reset outputs", {de_out, hs_out, vs_out}, 0);
        rst_n = 1'b1;
        idle(3);
        chk({de_out, hs_out, vs_out, de_drop, hs_drop, vs_drop} == 6'd0,
            "R1 outputs low after release", {de_out, hs_out, vs_out}, 0);
        idle(200);
        chk(de_out == 1'b1, "R1 baseline forwarded", de_out, 1);
        chk(drp[0] == 0, "R1 baseline no strobe", drp[0], 0);
        // the baseline must not spend budget: two fresh edges pass
        filt_en = 1'b0;
        idle(5);
        clr();
        @(negedge clk);
        de_in = 1'b0;
        @(negedge clk);
        de_in = 1'b1;
        idle(300);
        chk(tog[0] == 2, "R1 budget untouched by baseline", tog[0], 2);
        de_in = 1'b0;
        idle(300);

        // table walk
        for (int k = 0; k < 9; k++) begin
            int sel;
            sel = int'(VEC[k][15:14]);
            filt_en = VEC[k][13];
            idle(5);
            clr();
            pulse(sel, int'(VEC[k][12:4]));
            idle(450);
            chk(tog[sel] == int'(VEC[k][3:2]), {vtag[k], " toggles"}, tog[sel], int'(VEC[k][3:2]));
            chk(drp[sel] == int'(VEC[k][1:0]), {vtag[k], " strobes"}, drp[sel], int'(VEC[k][1:0]));
            chk(tog[0] + tog[1] + tog[2] == tog[sel], {vtag[k], " other outputs quiet"},
                tog[0] + tog[1] + tog[2], tog[sel]);
        end

        // R2: fixed latency on each signal and each setting
        latency(0, 1'b1, "R2 DE filtered");
        latency(1, 1'b0, "R2 HS unfiltered");
        latency(2, 1'b1, "R2 VS");

        // R8: VS output edges spaced by the input pulse of 130
        clr();
        pulse(2, 130);
        idle(450);
        chk(tog[2] == 2 && vs_gap >= 130, "R8 VS spacing", vs_gap, 130);

        // R5 and R9: third DE edge in window rejected, return not flagged
        filt_en = 1'b0;
        idle(5);
        clr();
        pulse(0, 1);
        idle(3);
        @(negedge clk);
        de_in = 1'b1;
        idle(3);
        chk(drp[0] == 1, "R5 third edge strobed", drp[0], 1);
        idle(10);
        de_in = 1'b0;
        idle(300);
        chk(tog[0] == 2, "R5 only two edges forwarded", tog[0], 2);
        chk(de_out == 1'b0 && drp[0] == 1, "R9 level kept, return silent", drp[0], 1);

        // R6: window boundary at 129 (dropped) and 130 (passed)
        idle(200);
        clr();
        @(negedge clk);
        de_in = 1'b1;
        @(negedge clk);
        de_in = 1'b0;
        idle(127);
        @(negedge clk);
        de_in = 1'b1;
        @(negedge clk);
        de_in = 1'b0;
        idle(300);
        chk(tog[0] == 2 && drp[0] == 1, "R6 edge at 129 dropped", drp[0], 1);
        idle(200);
        clr();
        @(negedge clk);
        de_in = 1'b1;
        @(negedge clk);
        de_in = 1'b0;
        idle(128);
        @(negedge clk);
        de_in = 1'b1;
        @(negedge clk);
        de_in = 1'b0;
        idle(300);
        chk(tog[0] == 4 && drp[0] == 0, "R6 edge at 130 passed", tog[0], 4);

        // R10: enable change during qualification is deferred
        filt_en = 1'b1;
        idle(200);
        clr();
        @(negedge clk);
        hs_in = 1'b1;
        @(negedge clk);
        filt_en = 1'b0;
        @(negedge clk);
        hs_in = 1'b0;
        idle(300);
        chk(tog[1] == 0 && drp[1] == 1, "R10 pulse judged by old setting", drp[1], 1);
        clr();
        pulse(1, 1);
        idle(300);
        chk(tog[1] == 2, "R10 new setting applied when idle", tog[1], 2);

        // R11: strobes counted one per reject in the rapid toggle run
        idle(200);
        clr();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            de_in = ~de_in;
        end
        idle(300);
        chk(tog[0] == 2 && drp[0] == 3, "R11 one strobe per reject", drp[0], 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule